// File: doc/BRIEF.md
# Interrupt Enable and Pending Controller

This block holds the enable and pending state for a bank of interrupt lines (64 by default) and presents one interrupt at a time to a processor core. Software reaches the state through a small register bus: one address, one write strobe, full 32-bit write data and combinational read data. Each function is spread over two 32-bit words, one bit per line. The enable state has two views: one where writing 1 sets bits and one where writing 1 clears them. The pending state has the same pair of views. All four views read back the state they act on.

A line goes pending whenever its interrupt input is high in a cycle, whether or not it is enabled. Only lines that are both enabled and pending compete for the core. Each line has a 4-bit priority, and the most urgent candidate is shown on `irq_valid`/`irq_id`. When the core acknowledges, that line's pending bit is cleared and the controller stays busy until an end-of-interrupt pulse. Nothing else is presented while it is busy.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every line is disabled and not pending, every priority is 0, and `irq_valid` is low.
- R2: A write to word address 0 (lines 0..31) or 1 (lines 32..63) enables each line whose data bit is 1. Bits written as 0 leave that line's enable unchanged.
- R3: A write to word address 2 (lines 0..31) or 3 (lines 32..63) disables each line whose data bit is 1. Bits written as 0 leave that line's enable unchanged.
- R4: Reading word address 0/1 or 2/3 returns the current enable state of those lines, with 1 meaning enabled.
- R5: Writing 1 to a bit at word address 4/5 makes that line pending. Writing 1 at word address 6/7 clears it. Bits written as 0 have no effect. All four addresses read back the pending state.
- R6: A line whose `irq_in` bit is high in a cycle becomes pending even while disabled. A line that is not both enabled and pending is never shown on `irq_valid`/`irq_id`.
- R7: Priorities live at word addresses 8..15. Line n uses word 8+n/8, bits [4*(n%8)+3 : 4*(n%8)], and these read back. Among enabled pending lines, the lowest value is presented. On equal values, the lower line number is presented.
- R8: When `irq_ack` is high while `irq_valid` is high, the presented line's pending bit is cleared at that clock edge. `irq_valid` then stays low until an `eoi` pulse.
- R9: If a line's `irq_in` bit is high in the same cycle as a clear-pending write to that line, the line ends pending.
- R10: Word addresses 16 and above read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_in | input | 64 | Interrupt inputs, one per line |
| irq_valid | output | 1 | An interrupt is presented |
| irq_id | output | 6 | Number of the presented line |
| irq_ack | input | 1 | Core accepts the presented interrupt |
| eoi | input | 1 | End of the active interrupt |

## Verification
Two updates can meet on the same pending bit in one cycle: a hardware input going high and a software clear-pending write to that line. The bench drives `irq_in` for a line during the very cycle its clear-pending write is strobed. It then reads the pending word and requires the bit to be set. The acknowledge path also clears pending bits, so acknowledges are checked by confirming that the acknowledged line drops out of the pending word while the lines that lost arbitration stay pending and are presented in priority order after each `eoi`.

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NUM_LINES = 64,
  parameter int PRIO_W    = 4,
  parameter int ADDR_W    = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_we,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  input  logic [NUM_LINES-1:0]         irq_in,
  output logic                         irq_valid,
  output logic [$clog2(NUM_LINES)-1:0] irq_id,
  input  logic                         irq_ack,
  input  logic                         eoi
);
  localparam int NW   = NUM_LINES / 32;
  localparam int LPW  = 32 / PRIO_W;
  localparam int PWDS = NUM_LINES / LPW;
  localparam int ID_W = $clog2(NUM_LINES);
  localparam int A_SEN = 0;
  localparam int A_CEN = NW;
  localparam int A_SPN = 2 * NW;
  localparam int A_CPN = 3 * NW;
  localparam int A_PRI = 4 * NW;

  logic [NUM_LINES-1:0] en_q, pend_q;
  logic [PRIO_W-1:0]    prio_q [NUM_LINES];
  logic                 busy_q;

  logic [NUM_LINES-1:0] set_en, clr_en, set_pn, clr_pn, ack_m;
  logic                 found;
  logic [PRIO_W-1:0]    best_p;
  logic [ID_W-1:0]      best_id;
  logic                 ack_fire;

  always_comb begin
    set_en = '0; clr_en = '0; set_pn = '0; clr_pn = '0;
    for (int w = 0; w < NW; w++) begin
      if (bus_we && bus_addr == ADDR_W'(A_SEN + w)) set_en[w*32 +: 32] = bus_wdata;
      if (bus_we && bus_addr == ADDR_W'(A_CEN + w)) clr_en[w*32 +: 32] = bus_wdata;
      if (bus_we && bus_addr == ADDR_W'(A_SPN + w)) set_pn[w*32 +: 32] = bus_wdata;
      if (bus_we && bus_addr == ADDR_W'(A_CPN + w)) clr_pn[w*32 +: 32] = bus_wdata;
    end
  end

  assign ack_fire = irq_valid & irq_ack;
  assign ack_m    = NUM_LINES'(ack_fire) << irq_id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      busy_q <= 1'b0;
      for (int i = 0; i < NUM_LINES; i++) prio_q[i] <= '0;
    end else begin
      en_q   <= (en_q & ~clr_en) | set_en;
      pend_q <= (pend_q & ~clr_pn & ~ack_m) | set_pn | irq_in;
      if (ack_fire)  busy_q <= 1'b1;
      else if (eoi)  busy_q <= 1'b0;
      for (int i = 0; i < NUM_LINES; i++)
        if (bus_we && bus_addr == ADDR_W'(A_PRI + i / LPW))
          prio_q[i] <= bus_wdata[(i % LPW) * PRIO_W +: PRIO_W];
    end
  end

  always_comb begin
    found   = 1'b0;
    best_p  = '1;
    best_id = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (en_q[i] && pend_q[i] && (!found || prio_q[i] < best_p)) begin
        found   = 1'b1;
        best_p  = prio_q[i];
        best_id = ID_W'(i);
      end
  end

  assign irq_valid = found & ~busy_q;
  assign irq_id    = best_id;

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NW; w++) begin
      if (bus_addr == ADDR_W'(A_SEN + w) || bus_addr == ADDR_W'(A_CEN + w))
        bus_rdata = en_q[w*32 +: 32];
      if (bus_addr == ADDR_W'(A_SPN + w) || bus_addr == ADDR_W'(A_CPN + w))
        bus_rdata = pend_q[w*32 +: 32];
    end
    for (int i = 0; i < NUM_LINES; i++)
      if (bus_addr == ADDR_W'(A_PRI + i / LPW))
        bus_rdata[(i % LPW) * PRIO_W +: PRIO_W] = prio_q[i];
  end

  AST_SETEN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(A_SEN) |=> (en_q[31:0] & $past(bus_wdata)) == $past(bus_wdata)); // R2
  AST_CLREN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(A_CEN) |=> (en_q[31:0] & $past(bus_wdata)) == 32'h0); // R3
  AST_ONLY_READY_PRESENTED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> en_q[irq_id] && pend_q[irq_id]); // R6
  AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack && !irq_in[irq_id] && !bus_we |=> !pend_q[$past(irq_id)]); // R8
  AST_ACK_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack |=> !irq_valid); // R8
  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in != '0 |=> (pend_q & $past(irq_in)) == $past(irq_in)); // R9
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] irq_in = '0;
  logic        irq_valid;
  logic [5:0]  irq_id;
  logic        irq_ack = 0, eoi = 0;
  int n_chk = 0, n_fail = 0;

  irq_ctrl dut (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
                .irq_in, .irq_valid, .irq_id, .irq_ack, .eoi);

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
  endtask

  task automatic pulse_eoi();
    @(negedge clk); eoi = 1; @(negedge clk); eoi = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(6'(a), d); check("R1 reset word", d, 32'h0);
    end
    check("R1 reset valid", 32'(irq_valid), 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(6'd0, 32'h0000_00F0); rd(6'd0, d); check("R2 set-enable", d, 32'h0000_00F0);
    wr(6'd0, 32'h0);         rd(6'd0, d); check("R2 zero write no effect", d, 32'h0000_00F0);
    rd(6'd2, d); check("R4 clear view reads enable", d, 32'h0000_00F0);
    wr(6'd1, 32'h8000_0001); rd(6'd1, d); check("R2 upper word", d, 32'h8000_0001);
    rd(6'd3, d); check("R4 upper clear view", d, 32'h8000_0001);
    wr(6'd2, 32'h0000_0030); rd(6'd0, d); check("R3 clear-enable", d, 32'h0000_00C0);
    wr(6'd2, 32'h0);         rd(6'd0, d); check("R3 zero write no effect", d, 32'h0000_00C0);
    wr(6'd2, 32'hFFFF_FFFF); wr(6'd3, 32'hFFFF_FFFF);
    rd(6'd1, d); check("R3 upper cleared", d, 32'h0);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    wr(6'd5, 32'h5); rd(6'd5, d); check("R5 set-pending", d, 32'h5);
    rd(6'd7, d); check("R5 clear view reads pending", d, 32'h5);
    check("R6 disabled not presented", 32'(irq_valid), 0);
    wr(6'd7, 32'h1); rd(6'd5, d); check("R5 clear-pending", d, 32'h4);
    wr(6'd7, 32'h0); rd(6'd5, d); check("R5 zero write no effect", d, 32'h4);
    wr(6'd7, 32'h4); rd(6'd5, d); check("R5 cleared all", d, 32'h0);
  endtask

  task automatic t_hw_disabled();
    logic [31:0] d;
    @(negedge clk); irq_in[10] = 1; @(negedge clk); irq_in[10] = 0;
    rd(6'd4, d); check("R6 hw sets pending while disabled", d, 32'h400);
    check("R6 disabled line not presented", 32'(irq_valid), 0);
    wr(6'd0, 32'h400);
    check("R6 enabled pending presented", 32'(irq_valid), 1);
    check("R6 presented id", 32'(irq_id), 10);
    wr(6'd6, 32'h400); wr(6'd2, 32'h400);
    check("R6 cleared not presented", 32'(irq_valid), 0);
  endtask

  task automatic t_priority_ack();
    logic [31:0] d;
    wr(6'd8, 32'h0000_5000);
    wr(6'd13, 32'h0000_0022);
    rd(6'd13, d); check("R7 priority readback", d, 32'h22);
    wr(6'd0, 32'h8); wr(6'd1, 32'h300);
    wr(6'd4, 32'h8); wr(6'd5, 32'h300);
    check("R7 tie valid", 32'(irq_valid), 1);
    check("R7 tie goes to lower line", 32'(irq_id), 40);
    wr(6'd8, 32'h0000_1000);
    check("R7 more urgent wins", 32'(irq_id), 3);
    pulse_ack();
    rd(6'd4, d); check("R8 ack clears pending", d, 32'h0);
    rd(6'd5, d); check("R8 others stay pending", d, 32'h300);
    check("R8 held off until eoi", 32'(irq_valid), 0);
    pulse_eoi();
    check("R8 next after eoi", 32'(irq_id), 40);
    check("R8 valid after eoi", 32'(irq_valid), 1);
    pulse_ack(); pulse_eoi();
    check("R7 then line 41", 32'(irq_id), 41);
    pulse_ack(); pulse_eoi();
    check("R8 none left", 32'(irq_valid), 0);
    wr(6'd2, 32'hFFFF_FFFF); wr(6'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    wr(6'd4, 32'h80);
    @(negedge clk); bus_addr = 6'd6; bus_wdata = 32'h80; bus_we = 1; irq_in[7] = 1;
    @(negedge clk); bus_we = 0; irq_in[7] = 0;
    rd(6'd4, d); check("R9 hw set beats clear", d, 32'h80);
    wr(6'd6, 32'h80); rd(6'd4, d); check("R9 clear alone works", d, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(6'd16, 32'hFFFF_FFFF); wr(6'd32, 32'hFFFF_FFFF);
    rd(6'd16, d); check("R10 unmapped reads zero", d, 32'h0);
    rd(6'd32, d); check("R10 unmapped reads zero hi", d, 32'h0);
    for (int a = 0; a < 8; a++) begin
      rd(6'(a), d); check("R10 state untouched", d, 32'h0);
    end
    rd(6'd9, d); check("R10 priority untouched", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_enable();
    t_pending();
    t_hw_disabled();
    t_priority_ack();
    t_set_wins();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule